// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. It takes two operands and a 5-bit condition field. Each bit of the field enables one relation between the operands: signed less, signed greater, equal, unsigned less and unsigned greater. The trap fires when at least one enabled relation holds.

A mode input selects the compare width. In word mode only the low 32 bits of each operand are compared, and the signed relations use bit 31 as the sign. In doubleword mode all 64 bits are compared.

The decision is registered. On the cycle after a valid strobe, the block raises a one-cycle trap request. With the request it gives a program-exception reason code that marks the cause as a trap, and the set of enabled relations that were true. Delivering the exception is left to the pipeline that sits downstream.

Top module: `trap_cond_eval`

## Requirements
- R1: After a synchronous active-low reset, trap_req_o is 0, trap_kind_o is 0 and trap_hits_o is 0.
- R2: Condition bit 4 (value 0x10) traps when opa is less than opb as two's-complement numbers.
- R3: Condition bit 3 (value 0x08) traps when opa is greater than opb as two's-complement numbers.
- R4: Condition bit 2 (value 0x04) traps when opa equals opb.
- R5: Condition bit 1 (value 0x02) traps when opa is less than opb as unsigned numbers. Condition bit 0 (value 0x01) traps when opa is greater than opb as unsigned numbers.
- R6: With dword_i = 0 (word mode), only bits 31:0 of each operand are compared, and bit 31 is the sign. Bits 63:32 have no effect on any output.
- R7: With dword_i = 1 (doubleword mode), all 64 bits are compared, and bit 63 is the sign.
- R8: In the cycle after a cycle with valid_i = 1, trap_hits_o equals the condition field ANDed with the relation vector. The relation vector has bit 4 = signed less, bit 3 = signed greater, bit 2 = equal, bit 1 = unsigned less and bit 0 = unsigned greater. trap_req_o is 1 exactly when trap_hits_o is nonzero. trap_kind_o is 3'd2 (trap reason) when trap_req_o is 1, and 3'd0 otherwise.
- R9: A condition field of 0 never traps. A condition field of 5'h1F always traps.
- R10: In the cycle after a cycle with valid_i = 0, all three outputs are 0, so each strobe gives a request of at most one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Strobe: evaluate the trap this cycle |
| dword_i | input | 1 | 1 = compare 64 bits, 0 = compare the low 32 bits |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| cond_i | input | 5 | Condition enable field |
| trap_req_o | output | 1 | One-cycle trap request |
| trap_kind_o | output | 3 | Reason code: 2 = trap, 0 = none |
| trap_hits_o | output | 5 | Enabled relations that were true |

## Verification
The bench sweeps every condition field in both modes over operand pairs chosen to expose the corner cases:
- **Sign boundaries at bit 31 and bit 63.** A design that used the wrong sign bit would swap signed less and signed greater on these pairs.
- **Upper halves that differ while the low words match, and the reverse.** A word mode that leaked the upper bits would report a false inequality, or miss an equality.
- **Pairs where the signed and unsigned orders disagree.** This catches a signed compare wired to an unsigned one.

Separate checks cover the field values 0 and 1F, and the cycle that follows each strobe. A design that held the request would leave it high past that cycle.

// File: rtl/trap_cond_pkg.sv
// Shared constants and types for the conditional trap comparator.
// Assumes a 5-bit condition field whose bit positions are fixed by the
// instruction encoding: the relation vector uses the same positions.
package trap_cond_pkg;
    localparam int COND_W = 5;
    localparam int KIND_W = 3;
    localparam int REL_SLT = 4;
    localparam int REL_SGT = 3;
    localparam int REL_EQ  = 2;
    localparam int REL_ULT = 1;
    localparam int REL_UGT = 0;

    typedef enum logic [KIND_W-1:0] {
        KIND_NONE = 3'd0,
        KIND_TRAP = 3'd2
    } trap_kind_e;
endpackage

// File: rtl/trap_rel_unit.sv
// Relation unit: compares two W-bit operands and returns the five
// relation flags in condition-field order. Purely combinational.
// Assumes the operands are already narrowed to the width that takes part.
module trap_rel_unit
    import trap_cond_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    output logic [COND_W-1:0] rel_o
);
    // Evaluate signed and unsigned orderings plus equality.
    always_comb begin
        rel_o          = '0;
        rel_o[REL_SLT] = $signed(a_i) <  $signed(b_i);
        rel_o[REL_SGT] = $signed(a_i) >  $signed(b_i);
        rel_o[REL_EQ]  = a_i == b_i;
        rel_o[REL_ULT] = a_i <  b_i;
        rel_o[REL_UGT] = a_i >  b_i;
    end
endmodule

// File: rtl/trap_cond_sel.sv
// Condition selector: masks the relation flags with the condition field
// and reduces them to a single fire decision. Purely combinational.
module trap_cond_sel
    import trap_cond_pkg::*;
(
    input  logic [COND_W-1:0] rel_i,
    input  logic [COND_W-1:0] cond_i,
    output logic [COND_W-1:0] hits_o,
    output logic              fire_o
);
    // Keep only the enabled relations and OR them together.
    always_comb begin
        hits_o = rel_i & cond_i;
        fire_o = |hits_o;
    end
endmodule

// File: rtl/trap_out_reg.sv
// Output stage: registers the trap decision once per strobe.
// A cycle without a strobe clears the outputs, so each request lasts
// exactly one cycle. Synchronous active-low reset.
module trap_out_reg
    import trap_cond_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              fire_i,
    input  logic [COND_W-1:0] hits_i,
    output logic              req_o,
    output logic [KIND_W-1:0] kind_o,
    output logic [COND_W-1:0] hits_o
);
    // Capture the decision when the strobe is high, and clear it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            kind_o <= KIND_NONE;
            hits_o <= '0;
        end else if (valid_i && fire_i) begin
            req_o  <= 1'b1;
            kind_o <= KIND_TRAP;
            hits_o <= hits_i;
        end else begin
            req_o  <= 1'b0;
            kind_o <= KIND_NONE;
            hits_o <= '0;
        end
    end
endmodule

// File: rtl/trap_cond_eval.sv
// Conditional trap comparator, top level.
// Two relation units run in parallel, one on the narrow word and one on
// the full width. dword_i picks one of them, the condition field masks it,
// and the decision is registered for one cycle per strobe.
// Assumes WORD_W <= DATA_W. When they are equal, the narrow unit is
// not built.
module trap_cond_eval
    import trap_cond_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              dword_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [COND_W-1:0] cond_i,
    output logic              trap_req_o,
    output logic [KIND_W-1:0] trap_kind_o,
    output logic [COND_W-1:0] trap_hits_o
);
    logic [COND_W-1:0] rel_full;
    logic [COND_W-1:0] rel_word;
    logic [COND_W-1:0] rel_sel;
    logic [COND_W-1:0] hits;
    logic              fire;

    trap_rel_unit #(.W(DATA_W)) u_rel_full (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .rel_o (rel_full)
    );

    generate
        if (WORD_W < DATA_W) begin : g_narrow
            trap_rel_unit #(.W(WORD_W)) u_rel_word (
                .a_i   (opa_i[WORD_W-1:0]),
                .b_i   (opb_i[WORD_W-1:0]),
                .rel_o (rel_word)
            );
        end else begin : g_same
            assign rel_word = rel_full;
        end
    endgenerate

    // Select the relation vector for the requested compare width.
    always_comb begin
        rel_sel = dword_i ? rel_full : rel_word;
    end

    trap_cond_sel u_sel (
        .rel_i  (rel_sel),
        .cond_i (cond_i),
        .hits_o (hits),
        .fire_o (fire)
    );

    trap_out_reg u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .fire_i  (fire),
        .hits_i  (hits),
        .req_o   (trap_req_o),
        .kind_o  (trap_kind_o),
        .hits_o  (trap_hits_o)
    );
endmodule

// File: rtl/trap_cond_eval_chk.sv
// Property checker for trap_cond_eval. It observes the ports only and is
// attached to every instance of the top by the bind statement below.
module trap_cond_eval_chk
    import trap_cond_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic              dword_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic [COND_W-1:0] cond_i,
    input logic              trap_req_o,
    input logic [KIND_W-1:0] trap_kind_o,
    input logic [COND_W-1:0] trap_hits_o
);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!trap_req_o && trap_hits_o == '0 && trap_kind_o == KIND_NONE));

    assert_zero_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cond_i == '0) |=> !trap_req_o);

    assert_full_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cond_i == '1) |=> trap_req_o);

    assert_hits_in_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> ((trap_hits_o & ~$past(cond_i)) == '0));

    assert_kind_matches_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |-> (trap_kind_o == KIND_TRAP && trap_hits_o != '0));

    assert_equal_dword_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dword_i && cond_i == 5'h04 && opa_i == opb_i) |=> trap_req_o);

    assert_signed_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_hits_o[REL_SLT] && trap_hits_o[REL_SGT]));

    assert_unsigned_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_hits_o[REL_ULT] && trap_hits_o[REL_UGT]));
endmodule

bind trap_cond_eval trap_cond_eval_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .dword_i     (dword_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .cond_i      (cond_i),
    .trap_req_o  (trap_req_o),
    .trap_kind_o (trap_kind_o),
    .trap_hits_o (trap_hits_o)
);

// File: tb/trap_cond_eval_tb_top.sv
module trap_cond_eval_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        dword_i = 1'b0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic [4:0]  cond_i = '0;
    logic        trap_req_o;
    logic [2:0]  trap_kind_o;
    logic [4:0]  trap_hits_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    trap_cond_eval dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .dword_i(dword_i),
        .opa_i(opa_i), .opb_i(opb_i), .cond_i(cond_i),
        .trap_req_o(trap_req_o), .trap_kind_o(trap_kind_o), .trap_hits_o(trap_hits_o)
    );

    localparam logic [63:0] VALS [10] = '{
        64'h0, 64'h1, 64'h7FFF_FFFF, 64'h8000_0000, 64'hFFFF_FFFF,
        64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000, 64'hDEAD_BEEF_0000_0005
    };

    // Reference relations, computed from the requirements.
    function automatic logic [4:0] ref_rel(input logic [63:0] a, input logic [63:0] b,
                                           input logic dw);
        logic [4:0] r;
        longint sa, sb;
        logic [63:0] ua, ub;
        if (dw) begin
            ua = a; ub = b;
            sa = $signed(a); sb = $signed(b);
        end else begin
            ua = {32'h0, a[31:0]}; ub = {32'h0, b[31:0]};
            sa = longint'($signed(a[31:0])); sb = longint'($signed(b[31:0]));
        end
        r[4] = sa < sb;
        r[3] = sa > sb;
        r[2] = ua == ub;
        r[1] = ua < ub;
        r[0] = ua > ub;
        return r;
    endfunction

    function automatic string tag_for(input logic [4:0] c, input logic dw);
        if (c == 5'h00 || c == 5'h1F) return "R9";
        if (c == 5'h10) return "R2";
        if (c == 5'h08) return "R3";
        if (c == 5'h04) return "R4";
        if (c == 5'h02 || c == 5'h01) return "R5";
        return dw ? "R7" : "R6";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One strobe. The outputs are checked in the cycle after it (R8) and
    // again in the quiet cycle that follows (R10).
    task automatic run(input logic [63:0] a, input logic [63:0] b,
                       input logic [4:0] c, input logic dw, input string tag);
        logic [4:0] eh;
        eh = ref_rel(a, b, dw) & c;
        @(negedge clk);
        opa_i = a; opb_i = b; cond_i = c; dword_i = dw; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        check(tag, "req", {63'h0, trap_req_o}, {63'h0, eh != 0});
        check("R8", "kind", {61'h0, trap_kind_o}, (eh != 0) ? 64'd2 : 64'd0);
        check(tag, "hits", {59'h0, trap_hits_o}, {59'h0, eh});
        @(negedge clk);
        check("R10", "quiet", {56'h0, trap_req_o, trap_kind_o, trap_hits_o}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset", {55'h0, trap_req_o, trap_kind_o, trap_hits_o}, 64'h0);
        rst_n = 1'b1;
        // Directed: upper halves ignored in word mode, used in doubleword mode.
        run(64'hFFFF_0000_0000_0003, 64'h0000_0001_0000_0003, 5'h04, 1'b0, "R6");
        run(64'hFFFF_0000_0000_0003, 64'h0000_0001_0000_0003, 5'h04, 1'b1, "R7");
        run(64'h1_0000_0000, 64'h0, 5'h01, 1'b1, "R7");
        run(64'h1_0000_0000, 64'h0, 5'h01, 1'b0, "R6");
        run(64'h0000_0000_8000_0000, 64'h0, 5'h10, 1'b0, "R6");
        run(64'h0000_0000_8000_0000, 64'h0, 5'h10, 1'b1, "R7");
        // Sweep: every field value, both modes, all operand pairs.
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 32; c++)
                for (int i = 0; i < 10; i++)
                    for (int j = 0; j < 10; j++)
                        run(VALS[i], VALS[j], 5'(c), 1'(m), tag_for(5'(c), 1'(m)));
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule